// File: doc/BRIEF.md
# Multicycle State Sequencer with Jump Counter

This block walks a small multicycle processor through the steps of each instruction. Five instruction classes are supported: register-register, OR-immediate, load, store and branch-on-equal. The current step is held in a 4-bit counter. On each clock edge the counter takes exactly one of four actions: clear to zero, add one, load a target from a built-in opcode table, or keep its value. Which action it takes depends on the current step, on the opcode held in the instruction register, and on two memory wait flags.

The datapath reads the step number, or the matching bit of a one-hot flag vector, to enable its own register transfers. A load or store stalls in its memory step while the data memory reports a wait. The fetch step stalls while the instruction memory reports a wait. When the decode step meets an opcode that is not in the table, the counter goes back to fetch and raises a one-cycle illegal-opcode strobe.

Top module: `mcseq_top`

## Requirements
- R1: A synchronous active-high reset sets the step to 0 (fetch) and drives `step_flags` to `16'h0001` and `bad_opcode` low on the following cycle.
- R2: In step 0 the counter keeps the value 0 while `imem_wait` is high. When `imem_wait` is low it moves to step 1 (decode) on the next edge.
- R3: In step 1 the next step comes from the opcode table: 6'b000000 gives 4, 6'b001101 gives 6, 6'b100011 gives 8, 6'b101011 gives 11 and 6'b000100 gives 3.
- R4: Any other opcode seen in step 1 sends the counter to step 0. `bad_opcode` is then high for exactly the one cycle in which the step first reads 0, and it is low at all other times.
- R5: The register-register class runs steps 4 then 5. The OR-immediate class runs steps 6 then 7. Each returns to step 0 after its second step.
- R6: The load class runs steps 8, 9 and 10, then returns to 0. Step 9 keeps its value while `dmem_wait` is high.
- R7: The store class runs steps 11 and 12, then returns to 0. Step 12 keeps its value while `dmem_wait` is high.
- R8: Step 3 (branch) lasts one cycle and is followed by step 0.
- R9: `step_flags` always has exactly one bit set, and that bit's index equals `step`.
- R10: Each wait flag affects only its own steps. `dmem_wait` has no effect in steps 0, 1, 4 and 8. `imem_wait` has no effect in every step except 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| imem_wait | input | 1 | Instruction memory not ready |
| dmem_wait | input | 1 | Data memory not ready |
| step | output | 4 | Current step number |
| step_flags | output | 16 | One-hot copy of the step number |
| bad_opcode | output | 1 | One-cycle strobe after decode of an unmapped opcode |

## Verification
The bench holds each memory wait flag high for several cycles in the steps where it applies. A sequencer that advanced anyway would skip a memory step, and one that stalled for only one cycle would leave that step too early. It also raises each wait flag in steps where it must have no effect, which exposes a hold condition that is not tied to the right step. It feeds unmapped opcodes next to mapped ones, so a table entry with a wrong target or a missing illegal strobe shows up as the wrong next step. A long run with pseudo-random opcodes and wait flags, plus a reset in mid-instruction, is compared cycle by cycle against a reference model.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;

  localparam int unsigned ST_W  = 4;
  localparam int unsigned OPC_W = 6;
  localparam int unsigned N_ST  = 1 << ST_W;

  typedef enum logic [1:0] {
    ACT_ZERO = 2'b00,
    ACT_INC  = 2'b01,
    ACT_LOAD = 2'b10,
    ACT_HOLD = 2'b11
  } ctr_act_e;

  // step numbers
  localparam logic [ST_W-1:0] S_FETCH  = 4'd0;
  localparam logic [ST_W-1:0] S_DECODE = 4'd1;
  localparam logic [ST_W-1:0] S_BRANCH = 4'd3;
  localparam logic [ST_W-1:0] S_RR_EX  = 4'd4;
  localparam logic [ST_W-1:0] S_RR_WB  = 4'd5;
  localparam logic [ST_W-1:0] S_OI_EX  = 4'd6;
  localparam logic [ST_W-1:0] S_OI_WB  = 4'd7;
  localparam logic [ST_W-1:0] S_LD_AG  = 4'd8;
  localparam logic [ST_W-1:0] S_LD_MEM = 4'd9;
  localparam logic [ST_W-1:0] S_LD_WB  = 4'd10;
  localparam logic [ST_W-1:0] S_ST_AG  = 4'd11;
  localparam logic [ST_W-1:0] S_ST_MEM = 4'd12;

  // opcodes
  localparam logic [OPC_W-1:0] OP_RR  = 6'b000000;
  localparam logic [OPC_W-1:0] OP_ORI = 6'b001101;
  localparam logic [OPC_W-1:0] OP_LD  = 6'b100011;
  localparam logic [OPC_W-1:0] OP_ST  = 6'b101011;
  localparam logic [OPC_W-1:0] OP_BEQ = 6'b000100;

  // Opcode table: returns {hit, target step}
  function automatic logic [ST_W:0] map_lookup(input logic [OPC_W-1:0] opc);
    logic [ST_W:0] r;
    unique case (opc)
      OP_RR:   r = {1'b1, S_RR_EX};
      OP_ORI:  r = {1'b1, S_OI_EX};
      OP_LD:   r = {1'b1, S_LD_AG};
      OP_ST:   r = {1'b1, S_ST_AG};
      OP_BEQ:  r = {1'b1, S_BRANCH};
      default: r = {1'b0, S_FETCH};
    endcase
    return r;
  endfunction

  // Counter arithmetic for one action
  function automatic logic [ST_W-1:0] apply_act(input ctr_act_e act,
                                                 input logic [ST_W-1:0] cur,
                                                 input logic [ST_W-1:0] tgt);
    logic [ST_W-1:0] r;
    unique case (act)
      ACT_ZERO: r = '0;
      ACT_INC:  r = cur + 1'b1;
      ACT_LOAD: r = tgt;
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mcseq_opmap.sv
module mcseq_opmap
  import mcseq_pkg::*;
#(
  parameter int unsigned OW = OPC_W,
  parameter int unsigned SW = ST_W
) (
  input  logic [OW-1:0] opcode,
  output logic          map_hit,
  output logic [SW-1:0] map_target
);
  logic [ST_W:0] entry;

  always_comb begin
    entry      = map_lookup(opcode);
    map_hit    = entry[ST_W];
    map_target = entry[SW-1:0];
  end

  // R3
  always_comb begin
    if (map_hit) begin
      map_target_valid_chk: assert (map_target inside {S_RR_EX, S_OI_EX, S_LD_AG, S_ST_AG, S_BRANCH})
        else $error("opcode table target out of set");
    end
  end
endmodule

// File: rtl/mcseq_act_sel.sv
module mcseq_act_sel
  import mcseq_pkg::*;
#(
  parameter int unsigned SW = ST_W
) (
  input  logic [SW-1:0] cur_step,
  input  logic          imem_wait,
  input  logic          dmem_wait,
  input  logic          map_hit,
  output ctr_act_e      action,
  output logic          wait_hit,
  output logic          decode_miss
);
  logic in_fetch, in_dmem;

  always_comb begin
    in_fetch    = (cur_step == S_FETCH);
    in_dmem     = (cur_step == S_LD_MEM) || (cur_step == S_ST_MEM);
    wait_hit    = (in_fetch && imem_wait) || (in_dmem && dmem_wait);
    decode_miss = (cur_step == S_DECODE) && !map_hit;
  end

  always_comb begin
    if (wait_hit) begin
      action = ACT_HOLD;
    end else begin
      unique case (cur_step)
        S_FETCH:  action = ACT_INC;
        S_DECODE: action = map_hit ? ACT_LOAD : ACT_ZERO;
        S_RR_EX, S_OI_EX, S_LD_AG, S_LD_MEM, S_ST_AG: action = ACT_INC;
        default:  action = ACT_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/mcseq_counter.sv
module mcseq_counter
  import mcseq_pkg::*;
#(
  parameter int unsigned SW = ST_W
) (
  input  logic          clk,
  input  logic          rst,
  input  ctr_act_e      action,
  input  logic [SW-1:0] load_val,
  output logic [SW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= apply_act(action, cnt, load_val);
  end

  // R6 R7 R2
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    action == ACT_HOLD |=> $stable(cnt));
  // R5 R6
  inc_steps_chk: assert property (@(posedge clk) disable iff (rst)
    action == ACT_INC |=> cnt == SW'($past(cnt) + 1'b1));
  // R3
  load_takes_chk: assert property (@(posedge clk) disable iff (rst)
    action == ACT_LOAD |=> cnt == $past(load_val));
  // R8 R4
  zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
    action == ACT_ZERO |=> cnt == '0);
endmodule

// File: rtl/mcseq_flag_dec.sv
module mcseq_flag_dec #(
  parameter int unsigned SW = 4,
  localparam int unsigned NF = 1 << SW
) (
  input  logic [SW-1:0] step,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    assign flags[i] = (step == SW'(i));
  end

  // R9
  always_comb begin
    flags_onehot_chk: assert ($onehot(flags) || $isunknown(step))
      else $error("step flags not one-hot");
  end
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top
  import mcseq_pkg::*;
#(
  parameter int unsigned SW = ST_W,
  parameter int unsigned OW = OPC_W,
  localparam int unsigned NF = 1 << SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode,
  input  logic          imem_wait,
  input  logic          dmem_wait,
  output logic [SW-1:0] step,
  output logic [NF-1:0] step_flags,
  output logic          bad_opcode
);
  logic          map_hit;
  logic [SW-1:0] map_target;
  ctr_act_e      action;
  logic          wait_hit;
  logic          decode_miss;

  mcseq_opmap #(.OW(OW), .SW(SW)) u_map (
    .opcode(opcode), .map_hit(map_hit), .map_target(map_target));

  mcseq_act_sel #(.SW(SW)) u_sel (
    .cur_step(step), .imem_wait(imem_wait), .dmem_wait(dmem_wait),
    .map_hit(map_hit), .action(action), .wait_hit(wait_hit),
    .decode_miss(decode_miss));

  mcseq_counter #(.SW(SW)) u_ctr (
    .clk(clk), .rst(rst), .action(action), .load_val(map_target), .cnt(step));

  mcseq_flag_dec #(.SW(SW)) u_dec (.step(step), .flags(step_flags));

  always_ff @(posedge clk) begin
    if (rst) bad_opcode <= 1'b0;
    else     bad_opcode <= decode_miss;
  end

  // R1
  reset_step_chk: assert property (@(posedge clk) rst |=> step == '0 && !bad_opcode);
  // R2
  fetch_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (step == S_FETCH && imem_wait) |=> step == S_FETCH);
  // R2
  fetch_go_chk: assert property (@(posedge clk) disable iff (rst)
    (step == S_FETCH && !imem_wait) |=> step == S_DECODE);
  // R4
  bad_at_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |-> step == S_FETCH);
  // R4
  bad_single_chk: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |=> !bad_opcode);
  // R8
  branch_once_chk: assert property (@(posedge clk) disable iff (rst)
    step == S_BRANCH |=> step == S_FETCH);
  // R6 R7
  mem_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ((step == S_LD_MEM || step == S_ST_MEM) && dmem_wait) |=> $stable(step));
  // R10
  wait_scope_chk: assert property (@(posedge clk) disable iff (rst)
    wait_hit |-> (step == S_FETCH || step == S_LD_MEM || step == S_ST_MEM));
  // R9
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    step_flags[step] && $countones(step_flags) == 1);
endmodule

// File: tb/mcseq_top_bench.sv
module mcseq_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic        imem_wait = 1'b0;
  logic        dmem_wait = 1'b0;
  logic [3:0]  step;
  logic [15:0] step_flags;
  logic        bad_opcode;

  int vectors = 0;
  int miscompares = 0;
  int exp_step = 0;
  bit exp_bad = 1'b0;
  bit finished = 1'b0;
  string tag = "R1";

  always #5 clk = ~clk;

  mcseq_top u_mcseq_top (
    .clk(clk), .rst(rst), .opcode(opcode), .imem_wait(imem_wait),
    .dmem_wait(dmem_wait), .step(step), .step_flags(step_flags),
    .bad_opcode(bad_opcode));

  // Reference: what the next step should be, step by step
  function automatic int ref_next(int s, int opc, bit iw, bit dw);
    if (s == 0) return iw ? 0 : 1;
    if (s == 1) begin
      if (opc == 0)  return 4;
      if (opc == 13) return 6;
      if (opc == 35) return 8;
      if (opc == 43) return 11;
      if (opc == 4)  return 3;
      return 0;
    end
    if (s == 9)  return dw ? 9 : 10;
    if (s == 12) return dw ? 12 : 0;
    if (s == 4 || s == 6 || s == 8 || s == 11) return s + 1;
    return 0;
  endfunction

  function automatic bit ref_unmapped(int opc);
    return !(opc == 0 || opc == 13 || opc == 35 || opc == 43 || opc == 4);
  endfunction

  task automatic check_all();
    vectors++;
    if (int'(step) != exp_step) begin
      miscompares++;
      $display("FAIL %s step got %0d expected %0d", tag, step, exp_step);
    end
    vectors++;
    if (step_flags != (16'h1 << exp_step)) begin
      miscompares++;
      $display("FAIL R9 flags got %h expected %h", step_flags, 16'h1 << exp_step);
    end
    vectors++;
    if (bad_opcode != exp_bad) begin
      miscompares++;
      $display("FAIL R4 bad_opcode got %0b expected %0b", bad_opcode, exp_bad);
    end
  endtask

  // one clock: drive, model, edge, compare
  task automatic cyc(bit r, int opc, bit iw, bit dw);
    int nxt;
    bit nbad;
    rst = r; opcode = 6'(opc); imem_wait = iw; dmem_wait = dw;
    if (r) begin
      nxt = 0; nbad = 1'b0;
    end else begin
      nxt  = ref_next(exp_step, opc, iw, dw);
      nbad = (exp_step == 1) && ref_unmapped(opc);
    end
    @(posedge clk);
    #1;
    exp_step = nxt;
    exp_bad  = nbad;
    check_all();
  endtask

  task automatic run_instr(string t, int opc, int iw_cycles, int dw_cycles);
    tag = t;
    for (int i = 0; i < iw_cycles; i++) cyc(0, opc, 1, 1);   // R2 stall, R10 dmem ignored
    cyc(0, opc, 0, 1);                                      // fetch -> decode, R10
    cyc(0, opc, 1, 1);                                      // decode, imem ignored (R10)
    while (exp_step != 0) begin
      if ((exp_step == 9 || exp_step == 12) && dw_cycles > 0) begin
        dw_cycles--;
        cyc(0, opc, 1, 1);
      end else if (exp_step == 4 || exp_step == 8) begin
        cyc(0, opc, 1, 1);                                  // R10 dmem ignored
      end else begin
        cyc(0, opc, 1, 0);
      end
    end
  endtask

  initial begin
    #150000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int pick [7] = '{0, 13, 35, 43, 4, 63, 2};
    tag = "R1";
    cyc(1, 0, 0, 0);
    cyc(1, 0, 1, 1);
    run_instr("R5", 0, 2, 0);    // R3 R5 register-register
    run_instr("R5", 13, 0, 0);   // R3 R5 OR-immediate
    run_instr("R6", 35, 1, 3);   // R3 R6 load with data stall
    run_instr("R7", 43, 0, 4);   // R3 R7 store with data stall
    run_instr("R8", 4, 3, 0);    // R3 R8 branch
    run_instr("R4", 63, 0, 0);   // R4 unmapped
    run_instr("R4", 2, 1, 0);    // R4 unmapped
    run_instr("R10", 35, 0, 0);  // R10 load, no stall
    // mid-instruction reset R1
    tag = "R1";
    cyc(0, 35, 0, 0);
    cyc(0, 35, 0, 0);
    cyc(0, 35, 0, 0);
    cyc(1, 35, 0, 1);
    // pseudo-random run R9
    tag = "R9";
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[11:0] == 12'h0, pick[int'(lf[2:0]) % 7], lf[5] & lf[6], lf[8]);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule